// File: doc/BRIEF.md
# Background Cancellation-Gain Calibrator

This block keeps a small noise-cancellation gain code at its best value while the loop it serves keeps running. It emits a slow, symmetric triangular test code, which logic outside the block turns into a small disturbance on an oscillator supply. It reads back signed samples of the loop's integrator output and weights each sample by the polarity of the test signal. The weighted sum over one full test period gives the direction of the next gain step.

When the cancellation is too weak, the test signal leaks into the integrator output in phase with itself and the code rises. When the cancellation is too strong, the leak has the opposite sign and the code falls. When the leak is gone the code holds. A programmable dead-band absorbs small residues so that the code does not toggle once it has settled.

A bias code that mirrors the gain code is provided for the proportional path: a lower gain code gives a higher bias. A manual override lets software force the gain code, and adaptation pauses while it is held. The test period and amplitude are parameters.

Top module: `tsig_gain_cal`

## Requirements
- R1: While enabled, the phase counter p runs over 0..4Q-1 (Q = QUARTER) and `test_code` = ((s(p) + Q) << AMP_SHIFT). Here s rises from 0 to +Q, falls to -Q and returns toward 0. Each cycle moves the code by exactly one step of 1<<AMP_SHIFT, and the first cycle after enabling shows the midpoint.
- R2: Over one period the correlator sums the integrator sample with weight +1 for p < 2Q and weight -1 for p >= 2Q, counting the sample present in the cycle where the phase is p.
- R3: Only at the last phase of a period does the gain code move. It moves up by one if the sum exceeds `dead_band`, down by one if the sum is below -`dead_band`, and the new value shows the next cycle.
- R4: The gain code saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R5: When |sum| <= `dead_band` at the end of a period, the gain code is unchanged.
- R6: `bias_code` always equals (2^GAIN_W-1) - `gain_code`.
- R7: With `cal_en` low, the phase returns to 0, `test_code` sits at the midpoint Q<<AMP_SHIFT from the next cycle, the correlation restarts, and the gain code holds.
- R8: While `ovr_en` is high, `gain_code` takes `ovr_code` in the next cycle and no adaptation step is applied. The correlation restarts after release, and the test signal keeps running.
- R9: After reset `gain_code` = GAIN_INIT (16 by default), `bias_code` = its mirror, and `test_code` is at the midpoint.
- R10: With a linear leakage proportional to (optimum - gain) x s(p), the code moves one step per period toward an in-range optimum, holds there without dithering, and follows a moved optimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_en | input | 1 | Runs the test signal and adaptation |
| integ_sample | input | SAMPLE_W | Signed integrator output sample |
| dead_band | input | DB_W | Unsigned correlation threshold |
| ovr_en | input | 1 | Force the gain code and pause adaptation |
| ovr_code | input | GAIN_W | Forced gain value |
| test_code | output | TC_W | Unsigned triangular test code |
| gain_code | output | GAIN_W | Cancellation gain code |
| bias_code | output | GAIN_W | Mirrored proportional bias code |

## Verification
The test code is swept over a whole period and compared cycle by cycle against a folded-counter formula. Three synthetic sample patterns isolate the correlation weights: positive only in the first half, positive only in the second half, and constant. They show a rising step, a falling step and no step, which separates a correct polarity split from a swapped or missing one. A linear leakage model of the loop then drives convergence from below, tracking of a moved optimum, dead-band holding at residues just under and over the threshold, and saturation with optima beyond both ends. Override and disable are each applied mid-stream, and the code is checked to hold or load as required.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // signed triangle value for phase p: 0 -> +q -> -q -> toward 0
  function automatic int tri_level(input int p, input int q);
    if (p < q)          return p;
    else if (p < 3 * q) return 2 * q - p;
    else                return p - 4 * q;
  endfunction

  function automatic int mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic step_e step_decide(input int sum, input int dead);
    if (sum > dead)  return STEP_UP;
    if (sum < -dead) return STEP_DOWN;
    return STEP_HOLD;
  endfunction

endpackage

// File: rtl/tgc_tri_gen.sv
module tgc_tri_gen
  import tgc_pkg::*;
#(
  parameter int QUARTER   = 8,
  parameter int AMP_SHIFT = 2,
  parameter int TC_W      = 7,
  parameter int PH_W      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [TC_W-1:0] test_code,
  output logic            pos_half,
  output logic            period_end
);
  localparam int PERIOD = 4 * QUARTER;
  localparam int STEP   = 1 << AMP_SHIFT;
  localparam logic [TC_W-1:0] MID = TC_W'(QUARTER << AMP_SHIFT);

  logic [PH_W-1:0] phase_q;

  assign period_end = en && (int'(phase_q) == PERIOD - 1);
  assign pos_half   = int'(phase_q) < 2 * QUARTER;
  assign test_code  = TC_W'((tri_level(int'(phase_q), QUARTER) + QUARTER) << AMP_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_q <= '0;
    else if (!en || period_end)  phase_q <= '0;
    else                         phase_q <= phase_q + 1'b1;
  end

  // R1: consecutive enabled cycles move the code by exactly one step
  p_tri_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(rst_n)) |->
      ((int'(test_code) - int'($past(test_code)) == STEP) ||
       (int'(test_code) - int'($past(test_code)) == -STEP)));

  // R7: disabled phase parks the code at the midpoint
  p_idle_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (test_code == MID));

endmodule

// File: rtl/tgc_correlator.sv
module tgc_correlator #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       pos_half,
  input  logic                       period_end,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [ACC_W-1:0]    sum
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] contrib;

  assign ext     = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
  assign contrib = pos_half ? ext : -ext;
  assign sum     = acc_q + contrib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc_q <= '0;
    else if (clear || period_end) acc_q <= '0;
    else                          acc_q <= sum;
  end

  // R7 / R8: a clear request empties the running correlation
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0));

  // R2: a fresh window starts from exactly one weighted sample
  p_window_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !clear) |=> (sum == contrib));

endmodule

// File: rtl/tgc_gain_step.sv
module tgc_gain_step
  import tgc_pkg::*;
#(
  parameter int GAIN_W    = 5,
  parameter int GAIN_INIT = 16,
  parameter int ACC_W     = 18,
  parameter int DB_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eval,
  input  logic signed [ACC_W-1:0] sum,
  input  logic [DB_W-1:0]         dead,
  input  logic                    ovr_en,
  input  logic [GAIN_W-1:0]       ovr_code,
  output logic [GAIN_W-1:0]       gain
);
  localparam logic [GAIN_W-1:0] G_MAX = '1;

  step_e dir;
  logic  in_band;

  assign in_band = mag(int'(sum)) <= int'({1'b0, dead});
  assign dir     = eval ? step_decide(int'(sum), int'({1'b0, dead})) : STEP_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain <= GAIN_W'(GAIN_INIT);
    else if (ovr_en) gain <= ovr_code;
    else begin
      case (dir)
        STEP_UP:   if (gain != G_MAX) gain <= gain + 1'b1;
        STEP_DOWN: if (gain != '0)    gain <= gain - 1'b1;
        default:   gain <= gain;
      endcase
    end
  end

  // R8: override loads the forced value
  p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |=> (gain == $past(ovr_code)));

  // R5: residue inside the dead-band leaves the code alone
  p_dead_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && in_band && !ovr_en) |=> $stable(gain));

  // R3: no movement away from a period end
  p_only_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval && !ovr_en) |=> $stable(gain));

  // R3: at most one step at a time
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en |=> ((int'(gain) - int'($past(gain)) <= 1) &&
                 (int'($past(gain)) - int'(gain) <= 1)));

  // R4: no wrap at either end
  p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain == G_MAX && !ovr_en) |=> (gain != '0));
  p_no_wrap_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain == '0 && !ovr_en) |=> (gain != G_MAX));

endmodule

// File: rtl/tsig_gain_cal.sv
module tsig_gain_cal #(
  parameter int QUARTER   = 8,
  parameter int AMP_SHIFT = 2,
  parameter int SAMPLE_W  = 12,
  parameter int GAIN_W    = 5,
  parameter int GAIN_INIT = 16,
  parameter int DB_W      = 16,
  parameter int TC_W      = $clog2(((2 * QUARTER) << AMP_SHIFT) + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cal_en,
  input  logic signed [SAMPLE_W-1:0] integ_sample,
  input  logic [DB_W-1:0]            dead_band,
  input  logic                       ovr_en,
  input  logic [GAIN_W-1:0]          ovr_code,
  output logic [TC_W-1:0]            test_code,
  output logic [GAIN_W-1:0]          gain_code,
  output logic [GAIN_W-1:0]          bias_code
);
  localparam int PERIOD = 4 * QUARTER;
  localparam int PH_W   = $clog2(PERIOD);
  localparam int ACC_W  = SAMPLE_W + PH_W + 1;
  localparam logic [GAIN_W-1:0] G_MAX = '1;

  logic pos_half;
  logic period_end;
  logic corr_clear;
  logic step_eval;
  logic signed [ACC_W-1:0] corr_sum;

  assign corr_clear = !cal_en || ovr_en;
  assign step_eval  = period_end && !ovr_en;

  tgc_tri_gen #(
    .QUARTER(QUARTER), .AMP_SHIFT(AMP_SHIFT), .TC_W(TC_W), .PH_W(PH_W)
  ) u_tri (
    .clk(clk), .rst_n(rst_n), .en(cal_en),
    .test_code(test_code), .pos_half(pos_half), .period_end(period_end)
  );

  tgc_correlator #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .clear(corr_clear), .pos_half(pos_half),
    .period_end(period_end), .sample(integ_sample), .sum(corr_sum)
  );

  tgc_gain_step #(
    .GAIN_W(GAIN_W), .GAIN_INIT(GAIN_INIT), .ACC_W(ACC_W), .DB_W(DB_W)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .eval(step_eval), .sum(corr_sum),
    .dead(dead_band), .ovr_en(ovr_en), .ovr_code(ovr_code), .gain(gain_code)
  );

  assign bias_code = G_MAX - gain_code;

  // R6: bias moves opposite to gain
  p_bias_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (gain_code > $past(gain_code))) |-> (bias_code < $past(bias_code)));

  // R7: disabled calibration holds the gain
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && !ovr_en) |=> $stable(gain_code));

endmodule

// File: tb/tsig_gain_cal_bench.sv
module tsig_gain_cal_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int AMP   = 2;
  localparam int SW    = 12;
  localparam int GW    = 5;
  localparam int PER   = 4 * Q;
  localparam int KLEAK = 2;
  localparam int MIDC  = Q << AMP;
  localparam int GMAX  = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_en = 1'b0;
  logic signed [SW-1:0] integ_sample;
  logic [15:0] dead_band = '0;
  logic ovr_en = 1'b0;
  logic [GW-1:0] ovr_code = '0;
  logic [6:0] test_code;
  logic [GW-1:0] gain_code;
  logic [GW-1:0] bias_code;

  int n_chk = 0;
  int n_bad = 0;
  int opt = 16;
  int mode = 3;
  int bp = 0;

  always #(CLK_P/2) clk = ~clk;

  tsig_gain_cal u_tsig_gain_cal (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .integ_sample(integ_sample),
    .dead_band(dead_band), .ovr_en(ovr_en), .ovr_code(ovr_code),
    .test_code(test_code), .gain_code(gain_code), .bias_code(bias_code)
  );

  // bench phase mirror
  always @(posedge clk) begin
    if (!rst_n || !cal_en) bp <= 0;
    else bp <= (bp == PER - 1) ? 0 : bp + 1;
  end

  always_comb begin
    int v;
    case (mode)
      0: v = KLEAK * (opt - int'(gain_code)) * ((int'(test_code) >>> AMP) - Q);
      1: v = (bp < 2 * Q) ? 5 : 0;
      2: v = (bp >= 2 * Q) ? 5 : 0;
      default: v = 5;
    endcase
    integ_sample = SW'(v);
  end

  function automatic int exp_tc(input int k);
    int u;
    int t;
    u = (k + Q) % PER;
    t = (u < 2 * Q) ? u : PER - u;
    return t << AMP;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_gain(input string req, input int exp);
    chk(req, int'(gain_code), exp);
    chk("R6", int'(bias_code), GMAX - exp);
  endtask

  task automatic run_periods(input int n);
    repeat (n * PER) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic align();
    while (bp != 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk_gain("R9", 16);
    chk("R9", int'(test_code), MIDC);

    // R7 disabled: stimulus that would step is ignored
    mode = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk_gain("R7", 16);
    chk("R7", int'(test_code), MIDC);

    // R1 sweep of one period
    mode = 0; opt = 16;
    cal_en = 1'b1;
    for (int k = 0; k < PER; k++) begin
      chk("R1", int'(test_code), exp_tc(k));
      @(posedge clk);
      @(negedge clk);
    end
    chk_gain("R10", 16);

    // R2 weight polarity
    mode = 1; run_periods(1); chk_gain("R2", 17);
    mode = 2; run_periods(1); chk_gain("R2", 16);
    mode = 3; run_periods(1); chk_gain("R2", 16);

    // R3 / R10 convergence one step per period
    mode = 0; opt = 20;
    for (int n = 1; n <= 4; n++) begin
      run_periods(1);
      chk_gain("R3", 16 + n);
    end
    run_periods(3); chk_gain("R10", 20);
    opt = 23; run_periods(3); chk_gain("R10", 23);

    // R5 dead-band: residue 256 held, 768 and 512 step
    dead_band = 16'd300;
    opt = 24; run_periods(2); chk_gain("R5", 23);
    opt = 26; run_periods(3); chk_gain("R5", 25);
    dead_band = '0;

    // R4 saturation
    opt = 40; run_periods(10); chk_gain("R4", 31);
    run_periods(4); chk_gain("R4", 31);
    opt = -10; run_periods(35); chk_gain("R4", 0);

    // R7 disable mid-period
    opt = 10;
    repeat (16) @(posedge clk);
    @(negedge clk);
    cal_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7", int'(test_code), MIDC);
    repeat (64) @(posedge clk);
    @(negedge clk);
    chk_gain("R7", 0);
    chk("R7", int'(test_code), MIDC);
    cal_en = 1'b1;
    run_periods(1); chk_gain("R7", 1);

    // R8 override
    ovr_en = 1'b1; ovr_code = 5'd7;
    @(posedge clk); @(negedge clk);
    chk_gain("R8", 7);
    run_periods(3); chk_gain("R8", 7);
    ovr_code = 5'd31;
    @(posedge clk); @(negedge clk);
    chk_gain("R8", 31);
    ovr_code = 5'd7;
    @(posedge clk); @(negedge clk);
    align();
    ovr_en = 1'b0;
    run_periods(1); chk_gain("R8", 8);
    ovr_en = 1'b1; ovr_code = 5'd31;
    @(posedge clk); @(negedge clk);
    align();
    ovr_en = 1'b0;
    run_periods(25); chk_gain("R10", 10);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule